// File: doc/BRIEF.md
# Base and Bound Address Translator

This block sits between a processor's address generation and the memory request path. Each request carries an effective address, a write flag and a supervisor-mode flag. A user-mode request is checked against a segment-length register (the bound). If it is inside the segment, the block relocates it by adding a base register and forwards it as a valid memory access. If it is outside the segment, the block raises a bounds-violation flag and suppresses the access. Supervisor requests are not relocated and are not checked.

The base and bound pair is loaded through a small configuration port. Only the supervisor can write or read back that port. Each program gets its own pair. To switch to another program, the supervisor loads that program's pair. A user-mode write to the port does nothing except raise a one-cycle privilege-fault pulse. Every result is registered, so it appears one clock after its request.

Top module: `bb_xlate`

## Requirements
- R1: For a user request (reqValid=1, reqSuper=0) with reqAddr < bound, the next cycle shows memValid=1, memAddr = (base + reqAddr) modulo 2^32, memWrite = reqWrite and boundFault=0.
- R2: For a user request with reqAddr >= bound, the next cycle shows boundFault=1, memValid=0, memWrite=0 and memAddr=0.
- R3: For a supervisor request (reqSuper=1), the next cycle shows memValid=1 and memAddr = reqAddr, whatever the values of base and bound.
- R4: During reset and right after it, base=0, bound=0 and every output is 0. Because bound is 0, every user request faults until the supervisor loads the registers.
- R5: A configuration write (cfgWrite=1, cfgSuper=1) loads base when cfgSel=0 and bound when cfgSel=1. The new value applies to requests from the following cycle on. A request in the same cycle as the write uses the old value.
- R6: A configuration write with cfgSuper=0 leaves both registers unchanged. It also gives privFault=1 in the next cycle only.
- R7: cfgRdData shows base (cfgSel=0) or bound (cfgSel=1) while cfgSuper=1, and shows 0 while cfgSuper=0. It follows its inputs without a clock.
- R8: A cycle with reqValid=0 gives memValid=0 and boundFault=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access request is present |
| reqAddr | input | 32 | Effective address |
| reqWrite | input | 1 | Request is a write |
| reqSuper | input | 1 | Requester is in supervisor mode |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects base, 1 selects bound |
| cfgData | input | 32 | Configuration write data |
| cfgSuper | input | 1 | Configuration access is made in supervisor mode |
| cfgRdData | output | 32 | Readback of the selected register (0 in user mode) |
| memValid | output | 1 | Forwarded memory access is valid |
| memAddr | output | 32 | Physical address |
| memWrite | output | 1 | Forwarded access is a write |
| boundFault | output | 1 | Bounds violation on the previous request |
| privFault | output | 1 | User-mode configuration write was rejected |

## Verification
The assertions assume that the configuration port makes at most one write per cycle. They also assume that the privilege flags are valid on every clock edge after reset, with no X values. The stimulus drives every input to a defined value on each falling edge. Random addresses are kept near the bound so that legal and illegal accesses both occur often. Random bound values stay small for the same reason. Separate directed steps cover an address equal to bound minus one, an address equal to bound, a relocation sum that wraps past 2^32, and a write that arrives in the same cycle as a request.

// File: rtl/bb_xlate_pkg.sv
package bb_xlate_pkg;
  typedef struct packed {
    logic loadBase;
    logic loadBound;
    logic grant;
    logic deny;
  } ctlStrobes_t;
endpackage

// File: rtl/bb_xlate_ctl.sv
module bb_xlate_ctl
  import bb_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        outOfBound,
  input  logic        cfgWrite,
  input  logic        cfgSel,
  input  logic        cfgSuper,
  output ctlStrobes_t strobes,
  output logic        boundFault,
  output logic        privFault
);
  logic cfgOk;

  always_comb begin
    cfgOk             = cfgWrite && cfgSuper;
    strobes.loadBase  = cfgOk && !cfgSel;
    strobes.loadBound = cfgOk && cfgSel;
    strobes.grant     = reqValid && !outOfBound;
    strobes.deny      = reqValid && outOfBound;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      boundFault <= 1'b0;
      privFault  <= 1'b0;
    end else begin
      boundFault <= strobes.deny;
      privFault  <= cfgWrite && !cfgSuper;
    end
  end

  // R6: a privilege fault only follows a rejected user write
  a_r6_priv_pulse: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> ($past(cfgWrite) && !$past(cfgSuper)));

  // R8: an idle cycle never produces a fault
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> !boundFault);
endmodule

// File: rtl/bb_xlate_dp.sv
module bb_xlate_dp
  import bb_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSuper,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cfgSel,
  input  logic              cfgSuper,
  output logic              outOfBound,
  output logic [ADDR_W-1:0] cfgRdData,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite
);
  localparam logic [ADDR_W-1:0] ZERO = '0;

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] boundReg;
  logic [ADDR_W-1:0] relocAddr;

  always_comb begin
    outOfBound = !reqSuper && (reqAddr >= boundReg);
    relocAddr  = reqSuper ? reqAddr : (reqAddr + baseReg);
    cfgRdData  = !cfgSuper ? ZERO : (cfgSel ? boundReg : baseReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= ZERO;
      boundReg <= ZERO;
      memValid <= 1'b0;
      memAddr  <= ZERO;
      memWrite <= 1'b0;
    end else begin
      if (strobes.loadBase)  baseReg  <= cfgData;
      if (strobes.loadBound) boundReg <= cfgData;
      memValid <= strobes.grant;
      memAddr  <= strobes.grant ? relocAddr : ZERO;
      memWrite <= strobes.grant && reqWrite;
    end
  end

  // R1: a forwarded user access is relocated by the base that was in force
  a_r1_relocate: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !$past(reqSuper)) |->
      (memAddr == $past(reqAddr) + $past(baseReg)));

  // R2: a forwarded user access lay inside the segment
  a_r2_inside: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !$past(reqSuper)) |-> ($past(reqAddr) < $past(boundReg)));

  // R3: supervisor accesses pass untranslated
  a_r3_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(reqSuper)) |-> (memAddr == $past(reqAddr)));
endmodule

// File: rtl/bb_xlate.sv
module bb_xlate
  import bb_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSuper,
  input  logic              cfgWrite,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cfgSuper,
  output logic [ADDR_W-1:0] cfgRdData,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic              boundFault,
  output logic              privFault
);
  ctlStrobes_t strobes;
  logic        outOfBound;

  bb_xlate_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .outOfBound (outOfBound),
    .cfgWrite   (cfgWrite),
    .cfgSel     (cfgSel),
    .cfgSuper   (cfgSuper),
    .strobes    (strobes),
    .boundFault (boundFault),
    .privFault  (privFault)
  );

  bb_xlate_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqSuper   (reqSuper),
    .cfgData    (cfgData),
    .cfgSel     (cfgSel),
    .cfgSuper   (cfgSuper),
    .outOfBound (outOfBound),
    .cfgRdData  (cfgRdData),
    .memValid   (memValid),
    .memAddr    (memAddr),
    .memWrite   (memWrite)
  );

  // R2: a violation and a forwarded access never coincide
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memValid, boundFault}));

  // R6: a rejected write leaves both relocation registers untouched
  a_r6_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    privFault |-> ($stable(u_dp.baseReg) && $stable(u_dp.boundReg)));

  // R2: a faulted request forwards no write
  a_r2_no_write: assert property (@(posedge clk) disable iff (!rstN)
    boundFault |-> (!memWrite && memAddr == '0));
endmodule

// File: tb/bb_xlate_test.sv
module bb_xlate_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSuper = 1'b0;
  logic [31:0] reqAddr = '0, cfgData = '0;
  logic        cfgWrite = 1'b0, cfgSel = 1'b0, cfgSuper = 1'b0;
  logic [31:0] cfgRdData, memAddr;
  logic        memValid, memWrite, boundFault, privFault;

  int total = 0;
  int bad = 0;
  logic [31:0] mBase = '0, mBound = '0;

  always #(PERIOD/2) clk = ~clk;

  bb_xlate uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .cfgWrite(cfgWrite),
    .cfgSel(cfgSel), .cfgData(cfgData), .cfgSuper(cfgSuper),
    .cfgRdData(cfgRdData), .memValid(memValid), .memAddr(memAddr),
    .memWrite(memWrite), .boundFault(boundFault), .privFault(privFault)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, predict from the behavioural model, compare after the edge
  task automatic step(input logic v, input logic [31:0] a, input logic w,
                      input logic s, input logic cw, input logic cs,
                      input logic [31:0] cd, input logic csup, input string tag);
    logic g;
    logic [31:0] eA;
    reqValid = v; reqAddr = a; reqWrite = w; reqSuper = s;
    cfgWrite = cw; cfgSel = cs; cfgData = cd; cfgSuper = csup;
    #1;
    chk(tag, "cfgRdData", cfgRdData, csup ? (cs ? mBound : mBase) : 32'h0);
    g  = v && (s || (a < mBound));
    eA = g ? (s ? a : a + mBase) : 32'h0;
    if (cw && csup) begin
      if (cs) mBound = cd; else mBase = cd;
    end
    @(negedge clk);
    chk(tag, "memValid",   {31'h0, memValid},   {31'h0, g});
    chk(tag, "memAddr",    memAddr,             eA);
    chk(tag, "memWrite",   {31'h0, memWrite},   {31'h0, g && w});
    chk(tag, "boundFault", {31'h0, boundFault}, {31'h0, v && !g});
    chk(tag, "privFault",  {31'h0, privFault},  {31'h0, cw && !csup});
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4: reset state
    chk("R4", "memValid",   {31'h0, memValid},   32'h0);
    chk("R4", "memAddr",    memAddr,             32'h0);
    chk("R4", "boundFault", {31'h0, boundFault}, 32'h0);
    chk("R4", "privFault",  {31'h0, privFault},  32'h0);
    rstN = 1'b1;
    step(1, 32'h0, 0, 0, 0, 0, 0, 0, "R4");            // user access faults after reset
    step(0, 0, 0, 0, 0, 0, 0, 1, "R7");                 // base reads 0
    step(0, 0, 0, 0, 1, 0, 32'h1000, 1, "R5");          // load base
    step(0, 0, 0, 0, 1, 1, 32'h100, 1, "R5");           // load bound
    step(1, 32'h10, 0, 0, 0, 1, 0, 1, "R1");
    step(1, 32'hFF, 1, 0, 0, 0, 0, 1, "R1");            // last legal word, write
    step(1, 32'h100, 1, 0, 0, 0, 0, 0, "R2");           // equal to bound
    step(1, 32'h5000, 1, 1, 0, 0, 0, 0, "R3");          // supervisor bypass
    step(0, 0, 0, 0, 1, 0, 32'hDEAD, 0, "R6");          // user write rejected
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6");                 // base still 0x1000
    step(0, 0, 0, 0, 0, 1, 0, 0, "R7");                 // user readback zero
    step(1, 32'h80, 0, 0, 1, 1, 32'h40, 1, "R5");       // same-cycle: old bound used
    step(1, 32'h80, 0, 0, 0, 0, 0, 0, "R5");            // new bound now faults
    step(0, 0, 0, 0, 1, 0, 32'hFFFF_FFF0, 1, "R5");
    step(0, 0, 0, 0, 1, 1, 32'hFFFF_FFFF, 1, "R5");
    step(1, 32'h20, 0, 0, 0, 0, 0, 0, "R1");            // wraps to 0x10
    step(0, 32'h20, 1, 0, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 300; i++) begin
      logic cs = 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 3) != 0), 32'($urandom_range(0, 32'h300)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0),
           1'($urandom_range(0, 7) == 0), cs,
           cs ? 32'($urandom_range(0, 32'h400)) : $urandom,
           1'($urandom_range(0, 2) != 0), "mix R1 R2 R3 R5 R6 R7 R8");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule